// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one burst request into the column addresses of that burst, one per clock. A controller presents a starting column, a burst-length code, an ordering select and an auto-precharge request together with a one-cycle start strobe. From the next clock on the block drives one column per cycle. Each column comes with a valid flag. A last-beat flag marks the final column, and an auto-precharge flag rides on the final column of a burst that ends on its own.

Two orderings are supported. Sequential ordering counts the low bits of the column upward and wraps inside the aligned burst window. Interleaved ordering XORs the low bits of the start column with the beat number. A full-page setting walks the whole 256-column row with wrap and never ends by itself. A stop input ends any burst early. A fresh start strobe abandons the running burst and begins the new one.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset `valid_o`, `last_o` and `ap_o` are 0, and they stay 0 until a start strobe is seen.
- R2: The first beat appears in the cycle after the clock edge that samples `start_i`. It carries the sampled `col_i` and has `valid_o`=1. Beat i appears i cycles after beat 0, with no gaps.
- R3: `bl_code_i` selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Any value from 4 to 7 selects full page.
- R4: Sequential ordering (`ilv_i`=0) with length L: beat i = (start − start mod L) + ((start mod L + i) mod L). The upper column bits never change.
- R5: Interleaved ordering (`ilv_i`=1) with length L: beat i = (start − start mod L) + ((start mod L) XOR i).
- R6: Full page: beat i = (start + i) mod 256. `ilv_i` is ignored. `last_o` is never raised unless a stop is given.
- R7: `last_o` is 1 exactly on beat L−1 of a burst that runs to its end. In the cycle after the last beat, `valid_o` is 0 unless a new start was sampled.
- R8: `stop_i` high at the edge that would produce the next beat of an active burst makes that beat the last one (`last_o`=1). No further beat follows. `stop_i` has no effect while idle.
- R9: `ap_o` is 1 only on the last beat of a non-full-page burst that reaches its natural end and was started with `ap_req_i`=1. It stays 0 for full-page bursts and for bursts cut short by a stop.
- R10: `start_i` during an active burst abandons it. The next cycle shows beat 0 of the new burst. `start_i` takes priority over a simultaneous `stop_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst with the parameters below |
| col_i | input | 8 | Starting column |
| bl_code_i | input | 3 | Burst length code (0..3 fixed, 4..7 full page) |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| ap_req_i | input | 1 | Auto-precharge wanted at natural end |
| stop_i | input | 1 | End the active burst at the next beat |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final one |
| ap_o | output | 1 | Auto-precharge indication on the final beat |

## Verification
The bench sweeps every start column against every fixed length in both orderings. Missing the window alignment would let a sequential burst carry into the upper bits. Using addition where XOR belongs would show up as soon as the start is misaligned. Full-page runs cross column 255 to catch a design that saturates or fails to wrap, or that raises `last_o` or `ap_o` by itself. Stop, stop-while-idle and restart-mid-burst cases target a design that emits an extra beat after stop, leaves auto-precharge set on an aborted burst, or carries old beats into a new burst.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  localparam int COL_W   = 8;
  localparam int CODE_W  = 3;
  localparam int MAX_LOG = 3;
  typedef logic [COL_W-1:0] col_t;
endpackage

// File: rtl/sdram_bl_decode.sv
module sdram_bl_decode #(
  parameter int COL_W   = 8,
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [COL_W-1:0]  mask_o,
  output logic [COL_W-1:0]  last_idx_o,
  output logic              full_o
);
  assign full_o = (int'(code_i) > MAX_LOG);

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_mask
      assign mask_o[b] = full_o || (b < int'(code_i));
    end
  endgenerate

  // for fixed lengths the final beat index equals the window mask
  assign last_idx_o = mask_o;
endmodule

// File: rtl/sdram_col_order.sv
module sdram_col_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;
  always_comb begin
    if (ilv_i) low = base_i ^ idx_i;
    else       low = base_i + idx_i;
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int COL_BITS = COL_W,
  parameter int CODE_BITS = CODE_W,
  parameter int LOG_MAX = MAX_LOG
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [COL_BITS-1:0]  col_i,
  input  logic [CODE_BITS-1:0] bl_code_i,
  input  logic                 ilv_i,
  input  logic                 ap_req_i,
  input  logic                 stop_i,
  output logic [COL_BITS-1:0]  col_o,
  output logic                 valid_o,
  output logic                 last_o,
  output logic                 ap_o
);
  logic [COL_BITS-1:0] dec_mask, dec_last;
  logic                dec_full;

  sdram_bl_decode #(.COL_W(COL_BITS), .CODE_W(CODE_BITS), .MAX_LOG(LOG_MAX)) u_dec (
    .code_i(bl_code_i), .mask_o(dec_mask), .last_idx_o(dec_last), .full_o(dec_full)
  );

  logic                act_q, full_q, ilv_q, ap_q;
  logic [COL_BITS-1:0] idx_q, base_q, mask_q, last_idx_q, nxt_col;

  sdram_col_order #(.COL_W(COL_BITS)) u_ord (
    .base_i(base_q), .idx_i(idx_q), .mask_i(mask_q), .ilv_i(ilv_q), .col_o(nxt_col)
  );

  logic is_end, single;
  assign is_end = !full_q && (idx_q == last_idx_q);
  assign single = !dec_full && (dec_last == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      full_q     <= 1'b0;
      ilv_q      <= 1'b0;
      ap_q       <= 1'b0;
      idx_q      <= '0;
      base_q     <= '0;
      mask_q     <= '0;
      last_idx_q <= '0;
      col_o      <= '0;
      valid_o    <= 1'b0;
      last_o     <= 1'b0;
      ap_o       <= 1'b0;
    end else if (start_i) begin
      base_q     <= col_i;
      mask_q     <= dec_mask;
      last_idx_q <= dec_last;
      full_q     <= dec_full;
      ilv_q      <= ilv_i && !dec_full;
      ap_q       <= ap_req_i && !dec_full;
      idx_q      <= COL_BITS'(1);
      act_q      <= !single;
      col_o      <= col_i;
      valid_o    <= 1'b1;
      last_o     <= single;
      ap_o       <= single && ap_req_i;
    end else if (act_q) begin
      col_o   <= nxt_col;
      valid_o <= 1'b1;
      last_o  <= is_end || stop_i;
      ap_o    <= is_end && ap_q;
      idx_q   <= idx_q + COL_BITS'(1);
      act_q   <= !(is_end || stop_i);
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      ap_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int COL_BITS = 8,
  parameter int CODE_BITS = 3,
  parameter int LOG_MAX = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_i,
  input logic [COL_BITS-1:0]  col_i,
  input logic [CODE_BITS-1:0] bl_code_i,
  input logic                 ilv_i,
  input logic                 ap_req_i,
  input logic                 stop_i,
  input logic [COL_BITS-1:0]  col_o,
  input logic                 valid_o,
  input logic                 last_o,
  input logic                 ap_o
);
  assert_last_valid_R7: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);
  assert_ap_on_last_R9: assert property (@(posedge clk) disable iff (rst)
    ap_o |-> last_o);
  assert_start_beat_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(col_i)));
  assert_gap_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);
  assert_no_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o) |=> valid_o);
  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && stop_i && !start_i) |=> last_o);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start_i) |=> !valid_o);
endmodule

bind sdram_col_seq sdram_col_seq_chk #(
  .COL_BITS(COL_BITS), .CODE_BITS(CODE_BITS), .LOG_MAX(LOG_MAX)
) u_chk (.*);

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, ilv_i = 1'b0, ap_req_i = 1'b0, stop_i = 1'b0;
  logic [7:0] col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic [7:0] col_o;
  logic valid_o, last_o, ap_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_col_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .col_i(col_i), .bl_code_i(bl_code_i),
    .ilv_i(ilv_i), .ap_req_i(ap_req_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .ap_o(ap_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int c, input int code, input bit ilv, input int i);
    int len, up, off;
    if (code >= 4) return (c + i) % 256;
    len = 1 << code;
    off = c % len;
    up  = c - off;
    if (ilv) return up + (off ^ i);
    return up + ((off + i) % len);
  endfunction

  // stop_beat < 0: natural end (fixed lengths only)
  task automatic run_burst(input int c, input int code, input bit ilv, input bit ap, input int stop_beat);
    bit full;
    int len, nb;
    full = (code >= 4);
    len  = full ? 0 : (1 << code);
    nb   = (stop_beat >= 0) ? stop_beat + 1 : len;
    @(negedge clk);
    start_i = 1; col_i = 8'(c); bl_code_i = 3'(code); ilv_i = ilv; ap_req_i = ap;
    @(negedge clk);
    start_i = 0; ilv_i = 0; ap_req_i = 0;
    for (int i = 0; i < nb; i++) begin
      chk(valid_o == 1, "R2 valid", int'(valid_o), 1);
      chk(int'(col_o) == exp_col(c, code, ilv, i), full ? "R6 col" : (ilv ? "R5 col" : "R4 col"),
          int'(col_o), exp_col(c, code, ilv, i));
      chk(last_o == (i == nb - 1), (stop_beat >= 0) ? "R8 last" : "R7 last", int'(last_o), int'(i == nb - 1));
      chk(ap_o == (ap && !full && i == len - 1 && i == nb - 1), "R9 ap", int'(ap_o),
          int'(ap && !full && i == len - 1 && i == nb - 1));
      stop_i = (stop_beat >= 0 && i == stop_beat - 1);
      @(negedge clk);
    end
    stop_i = 0;
    chk(valid_o == 0, "R7 gap", int'(valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(valid_o == 0 && last_o == 0 && ap_o == 0, "R1 reset", int'({valid_o, last_o, ap_o}), 0);
    // R3 R4 R5: sweep all columns, fixed lengths, both orderings
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int c = 0; c < 256; c++)
          run_burst(c, code, il[0], c[0], -1);
    // R6: full page crossing the row end, interleave and ap ignored
    run_burst(250, 7, 1, 1, 20);
    run_burst(3, 4, 0, 1, 300);
    run_burst(128, 5, 0, 0, 2);
    // R8 R9: stop cuts fixed burst, no ap
    run_burst(13, 3, 0, 1, 3);
    run_burst(13, 3, 1, 1, 7);
    // R8: stop while idle ignored
    @(negedge clk); stop_i = 1;
    @(negedge clk); chk(valid_o == 0, "R8 idle stop", int'(valid_o), 0);
    @(negedge clk); chk(valid_o == 0, "R8 idle stop", int'(valid_o), 0);
    stop_i = 0;
    // R10: restart mid-burst
    @(negedge clk); start_i = 1; col_i = 8'd10; bl_code_i = 3'd3;
    @(negedge clk); start_i = 0;
    chk(int'(col_o) == 10, "R10 first", int'(col_o), 10);
    @(negedge clk);
    chk(int'(col_o) == 11, "R10 second", int'(col_o), 11);
    run_burst(77, 2, 1, 1, -1);
    // R10: start wins over stop
    @(negedge clk); start_i = 1; col_i = 8'd40; bl_code_i = 3'd2; stop_i = 1;
    @(negedge clk); start_i = 0; stop_i = 0;
    chk(last_o == 0 && int'(col_o) == 40, "R10 start over stop", int'(last_o), 0);
    @(negedge clk);
    chk(int'(col_o) == 41 && valid_o == 1, "R10 continues", int'(col_o), 41);
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule